// File: doc/BRIEF.md
# Grouped Six-Channel Timer Counter Bank

This block holds six 16-bit up-counters that advance together on one shared count enable. Each channel owns a compare register and a 3-bit clear-source field. A channel whose clear field selects compare clearing returns to zero on the enabled cycle in which its counter equals its compare value. That clear also becomes an event for the other channels.

A group register holds one membership bit per channel. Once two or more channels are members, a bus write to any member's counter loads the written value into every member. A member whose clear field selects group clearing returns to zero whenever another member clears on its own compare match. If only one bit is set, that channel behaves as if it had no group.

A 16-bit stop register sits beside the counters. Its bit 13 freezes the whole bank at the end of the current bus cycle. While that bit is set, all other registers read as zero and cannot be written. A hardware-standby input reloads the stop register to its reset value. A software-standby input pauses counting and leaves the stop register alone.

Top module: `sync_timer_bank`

## Requirements
- R1: After reset, all counters, compare registers, clear fields and the group register are zero, and the stop register reads 0x3FFF, so the bank starts frozen.
- R2: Word address map. Address 0 is the group register (bits 5:0, bit n = channel n). Address 1 is the stop register. Channel n uses address 8+4n for its counter, 9+4n for its compare register and 10+4n for its clear field (bits 2:0). Every other address reads 0.
- R3: While stop bit 13 is 0, count_en is 1 and sw_standby is 0, every counter rises by one per clock and wraps from 0xFFFF to 0x0000. With count_en at 0 the counters hold.
- R4: A counter write to a channel outside an active group loads that channel only.
- R5: With two or more group bits set, a counter write to any member loads the same value into every member and into no other channel.
- R6: Clear field 001: on an enabled cycle where the counter equals the compare value, the counter becomes 0 on the next clock instead of incrementing.
- R7: Clear field 011 on a group member: the counter becomes 0 on the same clock as another member clears through R6. A channel with field 011 that is not an active member keeps counting.
- R8: With exactly one group bit set, that channel neither loads on another channel's write nor clears on another channel's clear.
- R9: When a counter write and a clear hit the same channel on the same clock, the clear wins and the counter becomes 0.
- R10: When stop bit 13 is 1, counters freeze starting with the clock after the write that set the bit. All addresses except 1 read 0, and writes to them are dropped. Only bit 13 has this effect.
- R11: hw_standby reloads the stop register with 0x3FFF. sw_standby pauses counting and leaves the stop register unchanged.
- R12: Clear field codes other than 001 and 011 behave as no clear. All three bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_standby | input | 1 | Hardware standby; reloads the stop register |
| sw_standby | input | 1 | Software standby; pauses counting |
| count_en | input | 1 | Shared count enable |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address (combinational) |

## Verification
The hardest case to reach is a preset write and a compare clear on the same clock. A channel with compare clearing must sit exactly on its compare value while counting is enabled, and the bus write must land on that same edge. The bench reaches this by presetting the counter to the compare value with count_en low. It then raises count_en and issues the counter write in one cycle, so the match, the group clear of a partner channel and the group load all collide on one edge.

// File: rtl/tmr_pkg.sv
// Shared constants for the grouped timer bank.
// Assumes a 3-bit clear-source field in every channel.
package tmr_pkg;
    localparam int CLR_W = 3;
    localparam logic [CLR_W-1:0] CLR_MATCH = 3'b001;  // clear on own compare match
    localparam logic [CLR_W-1:0] CLR_GROUP = 3'b011;  // clear with the group
endpackage

// File: rtl/tmr_channel.sv
// One timer channel: counter, compare register and clear-source field.
// Assumes: load and group_clr already qualified by the bus and group logic;
// run already folds in count enable, stop and standby.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_cmp,
    input  logic              wr_ctl,
    input  logic [CLR_W-1:0]  ctl_wdata,
    input  logic              group_clr,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic [CLR_W-1:0]  clr_sel_q,
    output logic              match_clr
);

    // Own compare-match clear event, also offered to the group.
    assign match_clr = run && (clr_sel_q == CLR_MATCH) && (cnt_q == cmp_q);

    // Counter: clear beats load, load beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (match_clr || group_clr) cnt_q <= '0;
        else if (load)                   cnt_q <= wdata;
        else if (run)                    cnt_q <= cnt_q + 1'b1;
    end

    // Compare register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // Clear-source field written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      clr_sel_q <= '0;
        else if (wr_ctl) clr_sel_q <= ctl_wdata;
    end

endmodule

// File: rtl/tmr_sync_grp.sv
// Group register and group fan-out of presets and clears.
// Assumes cnt_wr_hit is at most one-hot and already qualified by access rights.
// Membership counts only when two or more bits are set.
module tmr_sync_grp #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_grp,
    input  logic [NUM_CH-1:0] grp_wdata,
    input  logic [NUM_CH-1:0] cnt_wr_hit,
    input  logic [NUM_CH-1:0] match_evt,
    input  logic [NUM_CH-1:0] group_sel,
    output logic [NUM_CH-1:0] grp_q,
    output logic [NUM_CH-1:0] grp_eff,
    output logic [NUM_CH-1:0] load_vec,
    output logic [NUM_CH-1:0] group_clr
);
    localparam int PC_W = $clog2(NUM_CH + 1);

    logic [PC_W-1:0] members;
    logic            grp_active;
    logic            grp_write;

    // Group register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      grp_q <= '0;
        else if (wr_grp) grp_q <= grp_wdata;
    end

    // Number of set membership bits.
    always_comb begin
        members = '0;
        for (int i = 0; i < NUM_CH; i++) members = members + PC_W'(grp_q[i]);
    end

    assign grp_active = (members >= PC_W'(2));
    assign grp_eff    = grp_active ? grp_q : '0;
    assign grp_write  = |(cnt_wr_hit & grp_eff);

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            logic [NUM_CH-1:0] others;
            // Clear events from every other active member.
            always_comb begin
                others    = match_evt & grp_eff;
                others[n] = 1'b0;
            end
            assign load_vec[n]  = cnt_wr_hit[n] | (grp_eff[n] & grp_write);
            assign group_clr[n] = grp_eff[n] & group_sel[n] & (|others);
        end
    endgenerate

endmodule

// File: rtl/tmr_mstop.sv
// Stop register controlling the bank.
// Assumes hw_standby is synchronous to clk; writes are never blocked.
module tmr_mstop #(
    parameter int              DATA_W   = 16,
    parameter int              STOP_BIT = 13,
    parameter logic [DATA_W-1:0] RST_VAL = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_standby,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stop_q,
    output logic              stopped
);

    // Stop register: reset and hardware standby reload, bus writes update.
    always_ff @(posedge clk) begin
        if (!rst_n)          stop_q <= RST_VAL;
        else if (hw_standby) stop_q <= RST_VAL;
        else if (wr)         stop_q <= wdata;
    end

    assign stopped = stop_q[STOP_BIT];

endmodule

// File: rtl/sync_timer_bank.sv
// Top of the grouped timer bank: address decode, read mux and wiring
// of the channels, the group logic and the stop register.
// Assumes single-cycle bus accesses and a combinational read path.
module sync_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int STOP_BIT = 13,
    parameter logic [DATA_W-1:0] STOP_RST = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_standby,
    input  logic              sw_standby,
    input  logic              count_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] GRP_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STOP_ADDR = ADDR_W'(1);
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 4;

    logic [DATA_W-1:0] stop_q;
    logic              stopped;
    logic              run;
    logic              wr_ok;
    logic              wr_stop;
    logic [NUM_CH-1:0] grp_q, grp_eff, load_vec, group_clr;
    logic [NUM_CH-1:0] cnt_hit, cmp_hit, ctl_hit;
    logic [NUM_CH-1:0] match_evt, group_sel;
    logic [DATA_W-1:0] cnt_arr [NUM_CH];
    logic [DATA_W-1:0] cmp_arr [NUM_CH];
    logic [CLR_W-1:0]  sel_arr [NUM_CH];
    logic [NUM_CH*DATA_W-1:0] cnt_flat;

    assign wr_ok   = bus_sel && bus_wr && !stopped;
    assign wr_stop = bus_sel && bus_wr && (bus_addr == STOP_ADDR);
    assign run     = count_en && !stopped && !sw_standby;

    tmr_mstop #(
        .DATA_W(DATA_W), .STOP_BIT(STOP_BIT), .RST_VAL(STOP_RST)
    ) i_mstop (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby),
        .wr(wr_stop), .wdata(bus_wdata), .stop_q(stop_q), .stopped(stopped)
    );

    tmr_sync_grp #(.NUM_CH(NUM_CH)) i_grp (
        .clk(clk), .rst_n(rst_n),
        .wr_grp(wr_ok && (bus_addr == GRP_ADDR)),
        .grp_wdata(bus_wdata[NUM_CH-1:0]),
        .cnt_wr_hit(cnt_hit & {NUM_CH{wr_ok}}),
        .match_evt(match_evt), .group_sel(group_sel),
        .grp_q(grp_q), .grp_eff(grp_eff),
        .load_vec(load_vec), .group_clr(group_clr)
    );

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            assign cnt_hit[n]   = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n));
            assign cmp_hit[n]   = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n + 1));
            assign ctl_hit[n]   = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*n + 2));
            assign group_sel[n] = (sel_arr[n] == CLR_GROUP);
            assign cnt_flat[n*DATA_W +: DATA_W] = cnt_arr[n];

            tmr_channel #(.DATA_W(DATA_W)) i_ch (
                .clk(clk), .rst_n(rst_n), .run(run),
                .load(load_vec[n]), .wdata(bus_wdata),
                .wr_cmp(wr_ok && cmp_hit[n]),
                .wr_ctl(wr_ok && ctl_hit[n]),
                .ctl_wdata(bus_wdata[CLR_W-1:0]),
                .group_clr(group_clr[n]),
                .cnt_q(cnt_arr[n]), .cmp_q(cmp_arr[n]),
                .clr_sel_q(sel_arr[n]), .match_clr(match_evt[n])
            );
        end
    endgenerate

    // Read mux: stop register always visible, everything else hidden while stopped.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STOP_ADDR) begin
            bus_rdata = stop_q;
        end else if (!stopped) begin
            if (bus_addr == GRP_ADDR) bus_rdata = DATA_W'(grp_q);
            for (int i = 0; i < NUM_CH; i++) begin
                if (cnt_hit[i]) bus_rdata = cnt_arr[i];
                if (cmp_hit[i]) bus_rdata = cmp_arr[i];
                if (ctl_hit[i]) bus_rdata = DATA_W'(sel_arr[i]);
            end
        end
    end

endmodule

// File: rtl/tmr_checker.sv
// Property checker for sync_timer_bank, attached by bind.
// Assumes it sees the stop register, flattened counters and effective group.
module tmr_checker #(
    parameter int NUM_CH   = 6,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int STOP_BIT = 13,
    parameter logic [DATA_W-1:0] STOP_RST = 16'h3FFF
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hw_standby,
    input logic                     sw_standby,
    input logic                     count_en,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [DATA_W-1:0]        stop_q,
    input logic [NUM_CH*DATA_W-1:0] cnt_flat,
    input logic [NUM_CH-1:0]        grp_eff
);
    localparam logic [ADDR_W-1:0] STOP_ADDR = ADDR_W'(1);

    // R10: hidden registers read zero while stopped
    a_r10_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q[STOP_BIT] && bus_sel && !bus_wr && bus_addr != STOP_ADDR)
            |-> bus_rdata == '0);

    // R10: no counter moves while stopped
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q[STOP_BIT] |=> $stable(cnt_flat));

    // R3: no enable and no write means no change
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !(bus_sel && bus_wr)) |=> $stable(cnt_flat));

    // R11: hardware standby reloads the stop register
    a_r11_hw_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> stop_q == STOP_RST);

    // R11: software standby freezes counters and leaves stop register alone
    a_r11_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_standby && !hw_standby && !(bus_sel && bus_wr))
            |=> ($stable(cnt_flat) && $stable(stop_q)));

    // R8: a group is never a single channel
    a_r8_no_lone_member: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_eff) != 1);

endmodule

bind sync_timer_bank tmr_checker #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STOP_BIT(STOP_BIT), .STOP_RST(STOP_RST)
) i_chk (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .count_en(count_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .stop_q(stop_q),
    .cnt_flat(cnt_flat), .grp_eff(grp_eff)
);

// File: tb/test_sync_timer_bank.sv
`timescale 1ns/1ps
// Directed bench for sync_timer_bank: one task per scenario.
module test_sync_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_standby = 1'b0;
    logic        sw_standby = 1'b0;
    logic        count_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_timer_bank i_sync_timer_bank (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
        .count_en(count_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [4:0] a_cnt(int n); return 5'(8 + 4*n); endfunction
    function automatic logic [4:0] a_cmp(int n); return 5'(9 + 4*n); endfunction
    function automatic logic [4:0] a_ctl(int n); return 5'(10 + 4*n); endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [4:0] a, input logic [15:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run(input int n);
        count_en = 1'b1;
        repeat (n) @(negedge clk);
        count_en = 1'b0;
    endtask

    task automatic t_reset;
        expect_rd("R1 stop reg reset", 5'd1, 16'h3FFF);
        expect_rd("R10 group hidden while stopped", 5'd0, 16'h0000);
        wr(a_cmp(0), 16'h1234);
        run(5);
        wr(5'd1, 16'h0000);
        expect_rd("R1 counter held while stopped", a_cnt(0), 16'h0000);
        expect_rd("R10 write dropped while stopped", a_cmp(0), 16'h0000);
        expect_rd("R2 unmapped address", 5'd2, 16'h0000);
        expect_rd("R2 unmapped channel slot", 5'd11, 16'h0000);
    endtask

    task automatic t_count_wrap;
        wr(a_cnt(0), 16'hFFFE);
        run(3);
        expect_rd("R3 wrap", a_cnt(0), 16'h0001);
        expect_rd("R3 count", a_cnt(1), 16'h0003);
    endtask

    task automatic t_presets;
        wr(a_cnt(1), 16'h0010);
        expect_rd("R4 own load", a_cnt(1), 16'h0010);
        expect_rd("R4 neighbour untouched", a_cnt(0), 16'h0001);
        wr(5'd0, 16'h0006);
        expect_rd("R2 group readback", 5'd0, 16'h0006);
        wr(a_cnt(1), 16'h0055);
        expect_rd("R5 member loaded", a_cnt(2), 16'h0055);
        expect_rd("R5 non-member untouched", a_cnt(3), 16'h0003);
        wr(a_cnt(2), 16'h0077);
        expect_rd("R5 reverse load", a_cnt(1), 16'h0077);
        wr(5'd0, 16'h0001);
        wr(a_cnt(0), 16'h0099);
        expect_rd("R8 lone member own load", a_cnt(0), 16'h0099);
        expect_rd("R8 lone member no fan-out", a_cnt(1), 16'h0077);
    endtask

    task automatic t_own_clear;
        wr(5'd0, 16'h0000);
        wr(a_ctl(0), 16'h0001);
        wr(a_cmp(0), 16'h0003);
        wr(a_cnt(0), 16'h0000);
        run(4);
        expect_rd("R6 clear at match", a_cnt(0), 16'h0000);
        run(1);
        expect_rd("R6 restart after clear", a_cnt(0), 16'h0001);
    endtask

    task automatic t_group_clear;
        wr(5'd0, 16'h0003);
        wr(a_ctl(1), 16'h0003);
        wr(a_ctl(2), 16'h0003);
        wr(a_cnt(2), 16'h0100);
        wr(a_cnt(0), 16'h0000);
        run(4);
        expect_rd("R7 source cleared", a_cnt(0), 16'h0000);
        expect_rd("R7 member cleared", a_cnt(1), 16'h0000);
        expect_rd("R7 non-member keeps counting", a_cnt(2), 16'h0104);
        run(2);
        expect_rd("R7 member resumes", a_cnt(1), 16'h0002);
        wr(5'd0, 16'h0002);
        wr(a_cnt(0), 16'h0000);
        wr(a_cnt(1), 16'h0020);
        run(4);
        expect_rd("R8 lone member not cleared", a_cnt(1), 16'h0024);
    endtask

    task automatic t_clear_beats_load;
        wr(5'd0, 16'h0003);
        wr(a_cmp(0), 16'h0005);
        wr(a_cnt(0), 16'h0005);
        count_en = 1'b1;
        wr(a_cnt(0), 16'h0200);
        count_en = 1'b0;
        expect_rd("R9 clear over load", a_cnt(0), 16'h0000);
        expect_rd("R9 member clear over load", a_cnt(1), 16'h0000);
    endtask

    task automatic t_reserved;
        wr(5'd0, 16'h0000);
        wr(a_ctl(3), 16'hFFFF);
        expect_rd("R12 field readback", a_ctl(3), 16'h0007);
        wr(a_cmp(3), 16'h0002);
        wr(a_cnt(3), 16'h0000);
        run(4);
        expect_rd("R12 reserved code no clear", a_cnt(3), 16'h0004);
    endtask

    task automatic t_stop;
        wr(a_cnt(4), 16'h0000);
        count_en = 1'b1;
        wr(5'd1, 16'h2000);
        repeat (3) @(negedge clk);
        count_en = 1'b0;
        expect_rd("R10 stop reg visible", 5'd1, 16'h2000);
        expect_rd("R10 counter read zero", a_cnt(4), 16'h0000);
        wr(a_cnt(4), 16'h0300);
        wr(5'd1, 16'hDFFF);
        expect_rd("R10 halt after write cycle", a_cnt(4), 16'h0001);
    endtask

    task automatic t_standby;
        sw_standby = 1'b1;
        run(3);
        sw_standby = 1'b0;
        expect_rd("R11 sw standby pauses", a_cnt(4), 16'h0001);
        expect_rd("R11 sw standby keeps stop reg", 5'd1, 16'hDFFF);
        hw_standby = 1'b1;
        @(negedge clk);
        hw_standby = 1'b0;
        expect_rd("R11 hw standby reload", 5'd1, 16'h3FFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_count_wrap;
        t_presets;
        t_own_clear;
        t_group_clear;
        t_clear_beats_load;
        t_reserved;
        t_stop;
        t_standby;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule